// File: doc/BRIEF.md
# Prioritized Reset State Manager

This block decides which reset is in force at any moment and drives the processor and peripheral reset lines from that decision. Five sources compete: power-up, brownout, a watchdog event, a software reset command and an external reset pin that is gated by an enable bit. A fixed priority settles requests that arrive on the same clock edge. Each active reset state also has its own rules: some later sources may take over, some are dropped, and some restart the current pulse.

Each accepted reset holds the processor reset for a programmable number of clock cycles and then returns to idle. When a reset state is entered, its type is latched as a 3-bit code. The code stays readable after the reset ends, so boot software can learn why it restarted. While a software reset is running, a busy flag tells the issuer not to send another command. The power-up input also acts as the block's own asynchronous reset.

Top module: `rst_state_mgr`

## Requirements
- R1: Requests seen on the same edge from idle are ranked brownout over watchdog over software over user, and only the highest one is entered.
- R2: While `por_i` is high, both reset outputs are 1, `sw_busy_o` is 0 and `last_type_o` is 0. After release, the processor reset stays high for HOLD_CYCLES more samples, and every other source is ignored during that time.
- R3: Each entry into a reset state, and each restart of one, holds `cpu_rst_o` high for exactly HOLD_CYCLES clock cycles from the entering edge.
- R4: A brownout request enters brownout reset from any state except power-up. While `bod_i` stays high, the count keeps restarting.
- R5: During software reset, a watchdog event moves the block into watchdog reset and starts a fresh count.
- R6: During watchdog reset, software commands, user pin activity and repeated watchdog events are all ignored.
- R7: During software reset, the user pin and further software commands have no effect.
- R8: During user reset, software commands and watchdog events are ignored, and the pin being sampled low again restarts the count.
- R9: The pin is registered once. User reset is entered on the edge after the registered pin level reads 0 while `ext_en_i` is 1. When `ext_en_i` is 0, a low pin does nothing.
- R10: `sw_busy_o` is 1 exactly while the block is in software reset, and it clears when that reset ends or is preempted.
- R11: `last_type_o` takes the code of each entered state (0 power-up, 1 brownout, 2 watchdog, 3 software, 4 user) and keeps it unchanged while idle.
- R12: `periph_rst_o` equals `cpu_rst_o`, except during a software reset whose `sw_periph_i` was 0 at acceptance, when it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-up reset, asynchronous, active high |
| bod_i | input | 1 | Brownout request, level, active high |
| wdt_evt_i | input | 1 | Watchdog expiry event, one-cycle pulse |
| sw_req_i | input | 1 | Software reset command, one-cycle pulse |
| sw_periph_i | input | 1 | With a software command: also reset peripherals |
| ext_rst_ni | input | 1 | External reset pin, active low |
| ext_en_i | input | 1 | Allows the pin to start a user reset |
| cpu_rst_o | output | 1 | Processor reset, active high |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| sw_busy_o | output | 1 | Software reset in progress |
| last_type_o | output | 3 | Code of the most recently entered reset |

## Verification
The bench starts each non-power-up reset, injects every other source at several points inside its pulse, and compares the pulse length and type code with values worked out from the preemption rules. A design that honoured a blocked source would show a longer pulse and a wrong code. One that ignored a preemption would end early with the old code. It also walks all fifteen combinations of simultaneous requests, where a wrong rank latches the wrong type. Further checks cover the one-cycle pin latency and the disabled pin, a held brownout that must stretch the pulse, the busy flag clearing on watchdog takeover, and a peripheral reset that a partial software command must leave low.

// File: rtl/rstm_pkg.sv
package rstm_pkg;

    // State codes double as the reset type codes latched on entry.
    typedef enum logic [2:0] {
        ST_PWR  = 3'd0,
        ST_BOD  = 3'd1,
        ST_WDT  = 3'd2,
        ST_SW   = 3'd3,
        ST_USR  = 3'd4,
        ST_IDLE = 3'd7
    } rst_state_e;

    localparam int unsigned TYPE_W = 3;

endpackage

// File: rtl/rstm_arbiter.sv
module rstm_arbiter
    import rstm_pkg::*;
(
    input  rst_state_e state_i,
    input  logic       bod_i,
    input  logic       wdt_i,
    input  logic       sw_i,
    input  logic       usr_req_i,
    input  logic       usr_hold_i,
    output logic       enter_o,
    output rst_state_e target_o
);

    always_comb begin
        enter_o  = 1'b0;
        target_o = state_i;
        unique case (state_i)
            ST_IDLE: begin
                if (bod_i) begin
                    enter_o = 1'b1; target_o = ST_BOD;
                end else if (wdt_i) begin
                    enter_o = 1'b1; target_o = ST_WDT;
                end else if (sw_i) begin
                    enter_o = 1'b1; target_o = ST_SW;
                end else if (usr_req_i) begin
                    enter_o = 1'b1; target_o = ST_USR;
                end
            end
            ST_PWR: begin
                enter_o = 1'b0;
            end
            ST_BOD: begin
                if (bod_i) begin
                    enter_o = 1'b1; target_o = ST_BOD;
                end
            end
            ST_WDT: begin
                if (bod_i) begin
                    enter_o = 1'b1; target_o = ST_BOD;
                end
            end
            ST_SW: begin
                if (bod_i) begin
                    enter_o = 1'b1; target_o = ST_BOD;
                end else if (wdt_i) begin
                    enter_o = 1'b1; target_o = ST_WDT;
                end
            end
            ST_USR: begin
                if (bod_i) begin
                    enter_o = 1'b1; target_o = ST_BOD;
                end else if (usr_hold_i) begin
                    enter_o = 1'b1; target_o = ST_USR;
                end
            end
            default: begin
                enter_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rstm_hold_timer.sv
module rstm_hold_timer #(
    parameter int unsigned HOLD = 16
) (
    input  logic clk_i,
    input  logic por_i,
    input  logic load_i,
    input  logic run_i,
    output logic expired_o
);

    localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
    localparam logic [CW-1:0] LOAD_VAL = CW'(HOLD - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = LOAD_VAL;
        end else if (run_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            tmr_q.cnt <= LOAD_VAL;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = (tmr_q.cnt == '0);

endmodule

// File: rtl/rst_state_mgr.sv
module rst_state_mgr
    import rstm_pkg::*;
#(
    parameter int unsigned HOLD_CYCLES = 16
) (
    input  logic                clk_i,
    input  logic                por_i,
    input  logic                bod_i,
    input  logic                wdt_evt_i,
    input  logic                sw_req_i,
    input  logic                sw_periph_i,
    input  logic                ext_rst_ni,
    input  logic                ext_en_i,
    output logic                cpu_rst_o,
    output logic                periph_rst_o,
    output logic                sw_busy_o,
    output logic [TYPE_W-1:0]   last_type_o
);

    typedef struct packed {
        rst_state_e        state;
        logic [TYPE_W-1:0] kind;
        logic              sw_per;
        logic              ext;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    logic       enter;
    rst_state_e target;
    logic       expired;
    logic       in_reset;

    assign in_reset = (ctl_q.state != ST_IDLE);

    rstm_arbiter u_arb (
        .state_i    (ctl_q.state),
        .bod_i      (bod_i),
        .wdt_i      (wdt_evt_i),
        .sw_i       (sw_req_i),
        .usr_req_i  (!ctl_q.ext && ext_en_i),
        .usr_hold_i (!ctl_q.ext),
        .enter_o    (enter),
        .target_o   (target)
    );

    rstm_hold_timer #(
        .HOLD (HOLD_CYCLES)
    ) u_tmr (
        .clk_i     (clk_i),
        .por_i     (por_i),
        .load_i    (enter),
        .run_i     (in_reset),
        .expired_o (expired)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.ext = ext_rst_ni;
        if (enter) begin
            ctl_d.state = target;
            ctl_d.kind  = TYPE_W'(target);
            if (target == ST_SW) begin
                ctl_d.sw_per = sw_periph_i;
            end
        end else if (in_reset && expired) begin
            ctl_d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk_i or posedge por_i) begin
        if (por_i) begin
            ctl_q.state  <= ST_PWR;
            ctl_q.kind   <= TYPE_W'(ST_PWR);
            ctl_q.sw_per <= 1'b1;
            ctl_q.ext    <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cpu_rst_o    = in_reset;
    assign periph_rst_o = in_reset && !((ctl_q.state == ST_SW) && !ctl_q.sw_per);
    assign sw_busy_o    = (ctl_q.state == ST_SW);
    assign last_type_o  = ctl_q.kind;

endmodule

// File: rtl/rst_state_mgr_chk.sv
module rst_state_mgr_chk (
    input logic       clk_i,
    input logic       por_i,
    input logic       bod_i,
    input logic       wdt_evt_i,
    input logic       cpu_rst_o,
    input logic       periph_rst_o,
    input logic       sw_busy_o,
    input logic [2:0] last_type_o
);

    a_r10_busy_only_in_reset: assert property (@(posedge clk_i) disable iff (por_i)
        sw_busy_o |-> cpu_rst_o);

    a_r12_periph_within_cpu: assert property (@(posedge clk_i) disable iff (por_i)
        periph_rst_o |-> cpu_rst_o);

    a_r11_type_changes_in_reset: assert property (@(posedge clk_i) disable iff (por_i)
        !$stable(last_type_o) |-> cpu_rst_o);

    a_r2_powerup_not_preempted: assert property (@(posedge clk_i) disable iff (por_i)
        (cpu_rst_o && last_type_o == 3'd0) |=> (last_type_o == 3'd0));

    a_r6_watchdog_holds: assert property (@(posedge clk_i) disable iff (por_i)
        (cpu_rst_o && last_type_o == 3'd2 && !bod_i) |=> (last_type_o == 3'd2));

    a_r7_software_holds: assert property (@(posedge clk_i) disable iff (por_i)
        (sw_busy_o && !bod_i && !wdt_evt_i) |=> (last_type_o == 3'd3));

    a_r4_brownout_wins: assert property (@(posedge clk_i) disable iff (por_i)
        (bod_i && !(cpu_rst_o && last_type_o == 3'd0)) |=> (cpu_rst_o && last_type_o == 3'd1));

endmodule

bind rst_state_mgr rst_state_mgr_chk u_chk (
    .clk_i        (clk_i),
    .por_i        (por_i),
    .bod_i        (bod_i),
    .wdt_evt_i    (wdt_evt_i),
    .cpu_rst_o    (cpu_rst_o),
    .periph_rst_o (periph_rst_o),
    .sw_busy_o    (sw_busy_o),
    .last_type_o  (last_type_o)
);

// File: tb/rst_state_mgr_tb_top.sv
module rst_state_mgr_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int H          = 6;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       por, bod, wdt, sw, sw_per, pin_n, en;
    logic       cpu, per, busy;
    logic [2:0] ltype;
    int         errors = 0;
    int         checks = 0;
    int         cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rst_state_mgr #(.HOLD_CYCLES(H)) dut_i (
        .clk_i        (clk),
        .por_i        (por),
        .bod_i        (bod),
        .wdt_evt_i    (wdt),
        .sw_req_i     (sw),
        .sw_periph_i  (sw_per),
        .ext_rst_ni   (pin_n),
        .ext_en_i     (en),
        .cpu_rst_o    (cpu),
        .periph_rst_o (per),
        .sw_busy_o    (busy),
        .last_type_o  (ltype)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WD_LIMIT);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_inputs();
        bod = 1'b0; wdt = 1'b0; sw = 1'b0; pin_n = 1'b1; sw_per = 1'b1;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (!cpu) break;
        end
        @(negedge clk);
    endtask

    // Codes: 1 brownout, 2 watchdog, 3 software, 4 user.
    function automatic bit accepts(int st, int it);
        if (it == 1) return 1'b1;
        case (st)
            3:       return (it == 2);
            4:       return (it == 4);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string rule_tag(int st, int it);
        if (it == 1 || st == 1) return "R4";
        if (st == 2) return "R6";
        if (st == 3) return (it == 2) ? "R5" : "R7";
        return "R8";
    endfunction

    task automatic run_case(int st, int it, int k);
        int s    = (st == 4) ? 1 : 0;
        int ci   = s + k;
        int ceff = ci + ((it == 4) ? 1 : 0);
        bit acc  = accepts(st, it);
        int endx = acc ? ceff : s;
        int hi   = 0;
        int bad  = 0;
        int bad_act = 0;
        int bad_exp = 0;
        for (int c = 0; c <= endx + H + 3; c++) begin
            @(negedge clk);
            if (c >= s + 1) begin
                int et;
                et = (acc && c >= ceff + 1) ? it : st;
                if (cpu) hi++;
                if (c <= endx + H) begin
                    if (ltype != 3'(et) && bad == 0) begin
                        bad = 1; bad_act = int'(ltype); bad_exp = et;
                    end
                    if (busy != (et == 3) && bad == 0) begin
                        bad = 2; bad_act = int'(busy); bad_exp = (et == 3) ? 1 : 0;
                    end
                    if (per != cpu && bad == 0) begin
                        bad = 3; bad_act = int'(per); bad_exp = int'(cpu);
                    end
                end
            end
            bod   = (c == 0 && st == 1) || (c == ci && it == 1);
            wdt   = (c == 0 && st == 2) || (c == ci && it == 2);
            sw    = (c == 0 && st == 3) || (c == ci && it == 3);
            pin_n = !((c == 0 && st == 4) || (c == ci && it == 4));
        end
        clear_inputs();
        chk($sformatf("R3 %s pulse length st=%0d in=%0d k=%0d", rule_tag(st, it), st, it, k),
            hi, endx + H - s);
        chk($sformatf("R11 %s type after idle st=%0d in=%0d k=%0d", rule_tag(st, it), st, it, k),
            int'(ltype), acc ? it : st);
        if (bad == 1)
            chk($sformatf("R11 %s type timeline st=%0d in=%0d k=%0d", rule_tag(st, it), st, it, k), bad_act, bad_exp);
        else if (bad == 2)
            chk($sformatf("R10 busy timeline st=%0d in=%0d k=%0d", st, it, k), bad_act, bad_exp);
        else if (bad == 3)
            chk($sformatf("R12 periph timeline st=%0d in=%0d k=%0d", st, it, k), bad_act, bad_exp);
        else
            chk($sformatf("R10 R12 timelines st=%0d in=%0d k=%0d", st, it, k), 0, 0);
        wait_idle();
    endtask

    // mask bit0 brownout, bit1 watchdog, bit2 software, bit3 user
    task automatic prio(int mask);
        int exp_t = 0;
        for (int b = 3; b >= 0; b--) if (mask[b]) exp_t = b + 1;
        for (int c = 0; c <= 2; c++) begin
            @(negedge clk);
            if (c == 2) begin
                chk($sformatf("R1 cpu reset mask=%0d", mask), int'(cpu), 1);
                chk($sformatf("R1 type mask=%0d", mask), int'(ltype), exp_t);
            end
            pin_n = !(c == 0 && mask[3]);
            bod   = (c == 1) && mask[0];
            wdt   = (c == 1) && mask[1];
            sw    = (c == 1) && mask[2];
        end
        clear_inputs();
        wait_idle();
    endtask

    initial begin
        int hi;
        int prev_t;
        por = 1'b1; en = 1'b1;
        clear_inputs();
        repeat (3) @(negedge clk);
        chk("R2 cpu during por", int'(cpu), 1);
        chk("R2 periph during por", int'(per), 1);
        chk("R2 busy during por", int'(busy), 0);
        chk("R2 type during por", int'(ltype), 0);

        // Release power-up; brownout pulse during the hold is ignored.
        hi = 0;
        for (int c = 0; c <= H + 3; c++) begin
            @(negedge clk);
            if (cpu) hi++;
            if (c == 0) por = 1'b0;
            bod = (c == 2);
        end
        bod = 1'b0;
        chk("R2 power-up hold length", hi, H);
        chk("R2 type after power-up", int'(ltype), 0);
        wait_idle();

        // Simultaneous requests from idle, all combinations.
        for (int m = 1; m < 16; m++) prio(m);

        // Preemption sweep.
        for (int st = 1; st <= 4; st++)
            for (int it = 1; it <= 4; it++)
                for (int k = 1; k <= 3; k++)
                    run_case(st, it, k);

        // Pin ignored while disabled.
        prev_t = int'(ltype);
        en = 1'b0;
        hi = 0;
        for (int c = 0; c <= 5; c++) begin
            @(negedge clk);
            if (c >= 1 && cpu) hi++;
            pin_n = !(c <= 2);
        end
        chk("R9 disabled pin cpu high samples", hi, 0);
        chk("R9 disabled pin type unchanged", int'(ltype), prev_t);
        en = 1'b1;
        pin_n = 1'b1;

        // Pin latency of one register.
        @(negedge clk); pin_n = 1'b0;
        @(negedge clk); chk("R9 not yet entered", int'(cpu), 0); pin_n = 1'b1;
        @(negedge clk);
        chk("R9 user entered", int'(cpu), 1);
        chk("R9 user type", int'(ltype), 4);
        wait_idle();

        // Software reset without peripherals, then watchdog takeover.
        @(negedge clk); sw = 1'b1; sw_per = 1'b0;
        @(negedge clk); sw = 1'b0; sw_per = 1'b1;
        chk("R12 cpu in partial sw", int'(cpu), 1);
        chk("R12 periph held low", int'(per), 0);
        chk("R10 busy set", int'(busy), 1);
        @(negedge clk); wdt = 1'b1;
        @(negedge clk); wdt = 1'b0;
        chk("R5 type after takeover", int'(ltype), 2);
        chk("R12 periph after takeover", int'(per), 1);
        chk("R10 busy cleared", int'(busy), 0);
        wait_idle();

        // Brownout held for four cycles stretches the pulse.
        hi = 0;
        for (int c = 0; c <= H + 8; c++) begin
            @(negedge clk);
            if (c >= 1 && cpu) hi++;
            bod = (c <= 3);
        end
        bod = 1'b0;
        chk("R4 held brownout length", hi, 3 + H);
        chk("R4 held brownout type", int'(ltype), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule